// File: doc/BRIEF.md
# Single-Wire Pulse-Width Configuration Receiver

This block takes configuration over one input pin. Each bit is sent as a high pulse. A narrow pulse means 0 and a wide pulse means 1. A pulse whose width lies between the two limits is flagged as an error. The receiver groups decoded bits into 10-bit words, most significant bit first. It then runs a small command machine over those words. The machine has four states: normal operation, programming idle, store without lock and store with lock.

In normal operation only a fixed entry word has any effect. In programming idle, a header word names an opcode and a register index. A write header is followed by a payload word, which goes into one of six volatile shadow registers. The payload is visible on the outputs as soon as its last bit is decoded.

Store commands raise a one-cycle strobe for the external nonvolatile array and hold a busy timer. Once the timer runs out, the block returns to programming idle, or to normal operation if an exit word came in while the store was running. Storing with lock sets a flag that stays set until reset and blocks every later store.

Top module: `pwcfg_rx`

## Requirements
- R1: The synchronised pin is measured in clock cycles of high level. A pulse narrower than SHORT_W cycles decodes as bit 0, and one at least LONG_W cycles wide decodes as bit 1.
- R2: A pulse of width from SHORT_W to LONG_W-1 sets err_o, which stays set until reset. It also drops the bits already gathered for the current word, so the next pulse starts a fresh word.
- R3: Ten decoded bits, most significant first, form one word. The low time between pulses can be of any length and does not alter the decoded bits.
- R4: In normal operation (state_o = 0), only the word 10'b1011010011 has an effect, and it moves the block to programming idle (state_o = 1). Every other word leaves state_o and cfg_o unchanged.
- R5: In programming idle, a header with bits [9:6] = 4'b0001, bits [5:3] = 0 and index in bits [2:0] makes the next word the payload for shadow register index. Register k appears on cfg_o[10k+9:10k] one cycle after the payload word completes. Index 6 or 7 discards the payload.
- R6: In programming idle, opcode 4'b0010 (low bits zero) enters state 2 and opcode 4'b0011 enters state 3. Each entry raises nv_wr_o for exactly one cycle. nv_wr_lock_o is high with that strobe only for opcode 4'b0011, which also sets locked_o.
- R7: busy_o is high for exactly STORE_CYC consecutive cycles in each store state. After that the state returns to 1.
- R8: Opcode 4'b0100 in programming idle returns at once to state 0. If it arrives during a store, the store still runs to the end and then goes to state 0 instead of state 1.
- R9: While locked_o is set, both store opcodes are ignored: the state stays at 1 and nv_wr_o stays low.
- R10: After reset, state_o is 0 and cfg_o, nv_wr_o, nv_wr_lock_o, busy_o, locked_o and err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdin | input | 1 | Serial pulse-width data pin, asynchronous |
| cfg_o | output | 60 | Six shadow words; word k in bits [10k+9:10k] |
| state_o | output | 2 | 0 normal, 1 programming idle, 2 store, 3 store with lock |
| nv_wr_o | output | 1 | One-cycle strobe that starts a nonvolatile store |
| nv_wr_lock_o | output | 1 | Qualifies nv_wr_o as a locking store |
| busy_o | output | 1 | High while a store timer runs |
| locked_o | output | 1 | Lock flag, set by a locking store |
| err_o | output | 1 | Sticky flag for an ambiguous pulse width |

## Verification
The checker assumes that the pin is held high for at least one full clock for each pulse and that the block stays in reset long enough for the synchroniser to settle. It also assumes that no second store starts within the busy window, and the command machine ensures this by ignoring store opcodes outside programming idle. The stimulus drives the pin only on falling clock edges. It uses pulse widths well inside each class (2 cycles for 0, 10 for 1, 6 for the error band) and low gaps of at least 3 cycles. It keeps STORE_CYC long enough for a whole exit word to arrive during a store.

// File: rtl/pwcfg_pkg.sv
package pwcfg_pkg;

    localparam int WORD_W    = 10;
    localparam int NUM_WORDS = 6;
    localparam int IDX_W     = 3;
    localparam int OP_W      = 4;
    localparam int BITCNT_W  = $clog2(WORD_W);
    localparam int CFG_W     = WORD_W * NUM_WORDS;

    typedef enum logic [1:0] {
        ST_NORMAL   = 2'd0,
        ST_PROG     = 2'd1,
        ST_STORE    = 2'd2,
        ST_STORE_LK = 2'd3
    } state_e;

    localparam logic [OP_W-1:0] OP_WRITE    = 4'b0001;
    localparam logic [OP_W-1:0] OP_STORE    = 4'b0010;
    localparam logic [OP_W-1:0] OP_STORE_LK = 4'b0011;
    localparam logic [OP_W-1:0] OP_EXIT     = 4'b0100;

    localparam logic [WORD_W-1:0] ENTER_KEY = 10'b1011010011;

endpackage

// File: rtl/pwcfg_pulse_dec.sv
module pwcfg_pulse_dec #(
    parameter int SHORT_W = 4,
    parameter int LONG_W  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic bit_vld,
    output logic bit_val,
    output logic bit_err
);
    localparam int CNT_W = $clog2(LONG_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LONG_W);
    localparam logic [CNT_W-1:0] LIM_ZERO = CNT_W'(SHORT_W);
    localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(LONG_W);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic             vld;
        logic             val;
        logic             err;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d      = dec_q;
        dec_d.s1   = pin;
        dec_d.s2   = dec_q.s1;
        dec_d.prev = dec_q.s2;
        dec_d.vld  = 1'b0;
        dec_d.err  = 1'b0;
        if (dec_q.s2) begin
            if (dec_q.cnt != CNT_MAX) begin
                dec_d.cnt = dec_q.cnt + 1'b1;
            end
        end else begin
            dec_d.cnt = '0;
        end
        // falling edge: cnt holds the full high width
        if (dec_q.prev && !dec_q.s2) begin
            if (dec_q.cnt < LIM_ZERO) begin
                dec_d.vld = 1'b1;
                dec_d.val = 1'b0;
            end else if (dec_q.cnt >= LIM_ONE) begin
                dec_d.vld = 1'b1;
                dec_d.val = 1'b1;
            end else begin
                dec_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign bit_vld = dec_q.vld;
    assign bit_val = dec_q.val;
    assign bit_err = dec_q.err;

endmodule

// File: rtl/pwcfg_word_asm.sv
module pwcfg_word_asm
    import pwcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              bit_err,
    output logic              word_vld,
    output logic [WORD_W-1:0] word,
    output logic              err_flag
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0]   sh;
        logic [BITCNT_W-1:0] cnt;
        logic                vld;
        logic                err;
    } asm_t;

    asm_t asm_d, asm_q;

    always_comb begin
        asm_d     = asm_q;
        asm_d.vld = 1'b0;
        if (bit_err) begin
            asm_d.cnt = '0;
            asm_d.err = 1'b1;
        end else if (bit_vld) begin
            asm_d.sh = {asm_q.sh[WORD_W-2:0], bit_val};
            if (asm_q.cnt == LAST_BIT) begin
                asm_d.cnt = '0;
                asm_d.vld = 1'b1;
            end else begin
                asm_d.cnt = asm_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q <= '0;
        end else begin
            asm_q <= asm_d;
        end
    end

    assign word_vld = asm_q.vld;
    assign word     = asm_q.sh;
    assign err_flag = asm_q.err;

endmodule

// File: rtl/pwcfg_cmd_fsm.sv
module pwcfg_cmd_fsm
    import pwcfg_pkg::*;
#(
    parameter int STORE_CYC = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    output logic [CFG_W-1:0]  cfg,
    output logic [1:0]        state,
    output logic              nv_wr,
    output logic              nv_wr_lock,
    output logic              busy,
    output logic              locked
);
    localparam int TMR_W = $clog2(STORE_CYC + 1);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(STORE_CYC - 1);

    typedef struct packed {
        state_e                                st;
        logic [NUM_WORDS-1:0][WORD_W-1:0]      shadow;
        logic                                  hdr_pend;
        logic [IDX_W-1:0]                      idx;
        logic                                  lock;
        logic                                  exit_pend;
        logic [TMR_W-1:0]                      tmr;
        logic                                  wr;
        logic                                  wr_lk;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic [OP_W-1:0] op;
    logic            low_zero;

    assign op       = word[WORD_W-1 -: OP_W];
    assign low_zero = (word[WORD_W-OP_W-1:IDX_W] == '0);

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.wr    = 1'b0;
        fsm_d.wr_lk = 1'b0;
        unique case (fsm_q.st)
            ST_NORMAL: begin
                fsm_d.hdr_pend = 1'b0;
                if (word_vld && word == ENTER_KEY) begin
                    fsm_d.st = ST_PROG;
                end
            end
            ST_PROG: begin
                if (word_vld) begin
                    if (fsm_q.hdr_pend) begin
                        fsm_d.hdr_pend = 1'b0;
                        for (int k = 0; k < NUM_WORDS; k++) begin
                            if (fsm_q.idx == IDX_W'(k)) begin
                                fsm_d.shadow[k] = word;
                            end
                        end
                    end else if (op == OP_WRITE && low_zero) begin
                        fsm_d.hdr_pend = 1'b1;
                        fsm_d.idx      = word[IDX_W-1:0];
                    end else if (op == OP_STORE && low_zero && word[IDX_W-1:0] == '0) begin
                        if (!fsm_q.lock) begin
                            fsm_d.st        = ST_STORE;
                            fsm_d.tmr       = TMR_LOAD;
                            fsm_d.wr        = 1'b1;
                            fsm_d.exit_pend = 1'b0;
                        end
                    end else if (op == OP_STORE_LK && low_zero && word[IDX_W-1:0] == '0) begin
                        if (!fsm_q.lock) begin
                            fsm_d.st        = ST_STORE_LK;
                            fsm_d.tmr       = TMR_LOAD;
                            fsm_d.wr        = 1'b1;
                            fsm_d.wr_lk     = 1'b1;
                            fsm_d.lock      = 1'b1;
                            fsm_d.exit_pend = 1'b0;
                        end
                    end else if (op == OP_EXIT && low_zero && word[IDX_W-1:0] == '0) begin
                        fsm_d.st = ST_NORMAL;
                    end
                end
            end
            ST_STORE, ST_STORE_LK: begin
                if (word_vld && op == OP_EXIT && low_zero && word[IDX_W-1:0] == '0) begin
                    fsm_d.exit_pend = 1'b1;
                end
                if (fsm_q.tmr == '0) begin
                    fsm_d.st        = (fsm_q.exit_pend || fsm_d.exit_pend) ? ST_NORMAL : ST_PROG;
                    fsm_d.exit_pend = 1'b0;
                end else begin
                    fsm_d.tmr = fsm_q.tmr - 1'b1;
                end
            end
            default: fsm_d.st = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_cfg
        assign cfg[g*WORD_W +: WORD_W] = fsm_q.shadow[g];
    end

    assign state      = fsm_q.st;
    assign nv_wr      = fsm_q.wr;
    assign nv_wr_lock = fsm_q.wr_lk;
    assign busy       = (fsm_q.st == ST_STORE) || (fsm_q.st == ST_STORE_LK);
    assign locked     = fsm_q.lock;

endmodule

// File: rtl/pwcfg_rx.sv
module pwcfg_rx
    import pwcfg_pkg::*;
#(
    parameter int SHORT_W   = 4,
    parameter int LONG_W    = 8,
    parameter int STORE_CYC = 1250000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdin,
    output logic [CFG_W-1:0] cfg_o,
    output logic [1:0]       state_o,
    output logic             nv_wr_o,
    output logic             nv_wr_lock_o,
    output logic             busy_o,
    output logic             locked_o,
    output logic             err_o
);
    logic              bit_vld;
    logic              bit_val;
    logic              bit_err;
    logic              word_vld;
    logic [WORD_W-1:0] word;

    pwcfg_pulse_dec #(
        .SHORT_W (SHORT_W),
        .LONG_W  (LONG_W)
    ) dec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (sdin),
        .bit_vld (bit_vld),
        .bit_val (bit_val),
        .bit_err (bit_err)
    );

    pwcfg_word_asm asm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .bit_err  (bit_err),
        .word_vld (word_vld),
        .word     (word),
        .err_flag (err_o)
    );

    pwcfg_cmd_fsm #(
        .STORE_CYC (STORE_CYC)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_vld   (word_vld),
        .word       (word),
        .cfg        (cfg_o),
        .state      (state_o),
        .nv_wr      (nv_wr_o),
        .nv_wr_lock (nv_wr_lock_o),
        .busy       (busy_o),
        .locked     (locked_o)
    );

endmodule

// File: rtl/pwcfg_rx_chk.sv
module pwcfg_rx_chk
    import pwcfg_pkg::*;
#(
    parameter int STORE_CYC = 1250000
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_o,
    input logic [1:0]       state_o,
    input logic             nv_wr_o,
    input logic             nv_wr_lock_o,
    input logic             busy_o,
    input logic             locked_o,
    input logic             err_o
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    p_normal_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && $past(state_o) == 2'd0) |-> $stable(cfg_o));

    p_wr_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_o |-> (state_o[1] && $past(state_o) == 2'd1));

    p_wr_lock_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_lock_o |-> (nv_wr_o && locked_o));

    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_q == 32'(STORE_CYC)));

    p_busy_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !state_o[1]);

    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);

    p_no_wr_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked_o) |-> !nv_wr_o);

endmodule

bind pwcfg_rx pwcfg_rx_chk #(
    .STORE_CYC (STORE_CYC)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_o        (cfg_o),
    .state_o      (state_o),
    .nv_wr_o      (nv_wr_o),
    .nv_wr_lock_o (nv_wr_lock_o),
    .busy_o       (busy_o),
    .locked_o     (locked_o),
    .err_o        (err_o)
);

// File: tb/pwcfg_rx_tb_top.sv
module pwcfg_rx_tb_top;
    localparam int STORE_CYC = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdin = 1'b0;
    logic [59:0] cfg_o;
    logic [1:0]  state_o;
    logic        nv_wr_o, nv_wr_lock_o, busy_o, locked_o, err_o;

    always #4 clk = ~clk;

    pwcfg_rx #(.SHORT_W(4), .LONG_W(8), .STORE_CYC(STORE_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .sdin(sdin), .cfg_o(cfg_o), .state_o(state_o),
        .nv_wr_o(nv_wr_o), .nv_wr_lock_o(nv_wr_lock_o), .busy_o(busy_o),
        .locked_o(locked_o), .err_o(err_o)
    );

    typedef struct {
        string       tag;
        logic [59:0] cfg;
        logic [1:0]  st;
        logic        lk;
        logic        er;
    } exp_t;

    exp_t             sb_q[$];
    int               n_chk = 0;
    int               n_err = 0;
    logic [5:0][9:0]  m_cfg = '0;
    logic [1:0]       m_st = 2'd0;
    logic             m_lk = 1'b0;
    logic             m_er = 1'b0;
    int               wr_cnt = 0;
    logic             last_wr_lk = 1'b0;
    int               busy_run = 0;
    int               last_run = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input string tag);
        exp_t e;
        e.tag = tag; e.cfg = m_cfg; e.st = m_st; e.lk = m_lk; e.er = m_er;
        sb_q.push_back(e);
    endtask

    // monitor: compares expected items away from the active edge
    always @(posedge clk) begin
        #2;
        if (nv_wr_o) begin
            wr_cnt++;
            last_wr_lk = nv_wr_lock_o;
        end
        if (busy_o) busy_run++;
        else if (busy_run > 0) begin
            last_run = busy_run;
            busy_run = 0;
        end
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk({e.tag, " cfg"},    64'(cfg_o),    64'(e.cfg));
            chk({e.tag, " state"},  64'(state_o),  64'(e.st));
            chk({e.tag, " locked"}, 64'(locked_o), 64'(e.lk));
            chk({e.tag, " err"},    64'(err_o),    64'(e.er));
        end
    end

    task automatic pulse(input logic b, input int gap);
        @(negedge clk) sdin = 1'b1;
        repeat (b ? 10 : 2) @(negedge clk);
        sdin = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_word(input logic [9:0] w, input int gap);
        for (int i = 9; i >= 0; i--) pulse(w[i], gap);
        repeat (8) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [9:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        push("R10 reset");
        @(negedge clk);
        chk("R10 busy/strobes", 64'({busy_o, nv_wr_o, nv_wr_lock_o}), 64'd0);

        // R4: ignored words in normal operation
        send_word(10'h155, 3);
        push("R4 stray word");
        send_word(10'h040, 3);
        send_word(10'h3FF, 3);
        push("R4 write in normal");

        send_word(10'b1011010011, 3);
        m_st = 2'd1;
        push("R4 entry key");

        // R5/R1: fill all six words, including all-ones and all-zeros payloads
        for (int i = 0; i < 6; i++) begin
            v = (i == 0) ? 10'h3FF : (i == 1) ? 10'h000 : 10'((i * 10'h137) ^ 10'h2A5);
            send_word({4'b0001, 3'b000, 3'(i)}, 3);
            send_word(v, 3);
            m_cfg[i] = v;
            push("R5 R1 word write");
        end

        // R5: index 6 discarded
        send_word(10'h046, 3);
        send_word(10'h0AA, 3);
        push("R5 index 6 ignored");

        // R3: long gaps between bits
        send_word(10'h042, 60);
        send_word(10'h2C9, 60);
        m_cfg[2] = 10'h2C9;
        push("R3 long gaps");

        // R2: ambiguous pulse width, partial word dropped
        pulse(1'b1, 3); pulse(1'b0, 3); pulse(1'b1, 3); pulse(1'b1, 3);
        @(negedge clk) sdin = 1'b1;
        repeat (6) @(negedge clk);
        sdin = 1'b0;
        repeat (10) @(negedge clk);
        m_er = 1'b1;
        push("R2 error flag");
        send_word(10'h043, 3);
        send_word(10'h1E7, 3);
        m_cfg[3] = 10'h1E7;
        push("R2 realigned write");

        // R6/R7: plain store
        send_word(10'h080, 3);
        m_st = 2'd2;
        push("R6 store entry");
        @(negedge clk);
        chk("R6 strobe count", 64'(wr_cnt), 64'd1);
        chk("R6 lock qualifier low", 64'(last_wr_lk), 64'd0);
        wait_idle();
        chk("R7 busy length", 64'(last_run), 64'(STORE_CYC));
        m_st = 2'd1;
        push("R7 back to idle");

        // R8: exit requested during store
        send_word(10'h080, 3);
        m_st = 2'd2;
        send_word(10'h100, 3);
        push("R8 exit pending holds store");
        wait_idle();
        chk("R8 busy length", 64'(last_run), 64'(STORE_CYC));
        m_st = 2'd0;
        push("R8 exit after store");

        send_word(10'b1011010011, 3);
        m_st = 2'd1;
        push("R4 re-entry");

        // R6: locking store
        send_word(10'h0C0, 3);
        m_st = 2'd3;
        m_lk = 1'b1;
        push("R6 lock store entry");
        @(negedge clk);
        chk("R6 lock strobe count", 64'(wr_cnt), 64'd3);
        chk("R6 lock qualifier high", 64'(last_wr_lk), 64'd1);
        wait_idle();
        chk("R7 lock busy length", 64'(last_run), 64'(STORE_CYC));
        m_st = 2'd1;
        push("R7 lock back to idle");

        // R9: stores ignored when locked
        send_word(10'h080, 3);
        push("R9 store ignored");
        send_word(10'h0C0, 3);
        push("R9 lock store ignored");
        chk("R9 no strobe", 64'(wr_cnt), 64'd3);

        // R8: exit from programming idle
        send_word(10'h100, 3);
        m_st = 2'd0;
        push("R8 exit from idle");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule